// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs a short, software-defined series of bus operations against a parallel NAND flash device with an 8-bit data bus. Before a run, software sets two generic command bytes, a column and a row address, a list of up to eight 3-bit step codes, the page geometry and a buffer selection. It then pulses `start`. The sequencer executes the steps one after another. It drives the command latch, address latch, write strobe and read strobe, and it waits on the device ready line when a step asks for that. When the list is finished it raises one completion pulse.

Page data never passes through software one byte at a time. A write step streams a whole page plus its spare area out of an internal 4-Kbyte byte buffer. A read step streams a whole page plus spare into that buffer. Software fills and empties the buffer through a simple host port. The buffer can be treated as two 2-Kbyte halves or as eight 512-byte slots. This lets software work on one region while the sequencer moves another.

Top module: `nand_cmd_seq`

## Requirements
- R1: Step codes sit in `step_list`, with step k in bits [3k+2:3k]. The codes are 0 end, 1 first command, 2 second command, 3 column address, 4 row address, 5 write page, 6 read page and 7 wait for ready. Steps run from step 0 upward, and the run ends at the first code 0 or after step 7.
- R2: Code 1 issues one byte equal to `cmd0`, and code 2 issues one byte equal to `cmd1`. Each is sent with `nf_cle` high and `nf_ale` low.
- R3: Code 3 issues `col_addr[7:0]` only when `large_page`=0. When `large_page`=1 it issues `col_addr[7:0]` and then `col_addr[15:8]`. Code 4 issues the row bytes, least significant first. Every address byte is sent with `nf_ale` high and `nf_cle` low. `nf_cle` and `nf_ale` are never high together.
- R4: A written byte takes one cycle with `nf_we_n` low and one cycle with it high. `nf_dq_oe` is high and `nf_dq_out` does not change across the rising edge. `nf_we_n` and `nf_re_n` are never low at the same time.
- R5: Code 5 sends a full page plus spare from the buffer: 528 bytes when `large_page`=0 and 2112 bytes when it is 1. Byte i comes from buffer address (base+i) mod 4096.
- R6: Code 6 performs the same number of read strobes as code 5 sends bytes. Each byte is sampled on `nf_dq_in` at the clock edge where `nf_re_n` rises. Read byte j is stored at (base+j) mod 4096, with j counted from the start of the run. `nf_dq_oe` stays low while `nf_re_n` is low.
- R7: The buffer base depends on `buf_mode`. When `buf_mode`=0 the base is `buf_sel[0]`×2048. When `buf_mode`=1 the base is `buf_sel`×512.
- R8: Code 7 holds the sequence, with no strobes, until `nf_rb` is high. It then continues with the next step and leaves `timeout_flag` low.
- R9: During code 7, if `nf_rb` stays low for more than `timeout_lim` cycles, `timeout_flag` is set and the remaining steps are skipped. `timeout_flag` is cleared by the next accepted start.
- R10: `done_irq` is a one-cycle pulse in the first cycle in which `busy` is low after a run. A `start` seen while `busy` is high is ignored.
- R11: After reset, `busy`, `done_irq`, `timeout_flag`, `nf_cle`, `nf_ale` and `nf_dq_oe` are low, and `nf_we_n` and `nf_re_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| step_list | input | 24 | Eight 3-bit step codes, step 0 in the low bits |
| cmd0 | input | 8 | First generic command byte |
| cmd1 | input | 8 | Second generic command byte |
| col_addr | input | 16 | Column address |
| row_addr | input | 24 | Row address, three bytes |
| large_page | input | 1 | 1 selects 2048+64 geometry, 0 selects 512+16 |
| buf_mode | input | 1 | 0 means two halves, 1 means eight slots |
| buf_sel | input | 3 | Buffer half or slot number |
| timeout_lim | input | 16 | Ready-wait limit in cycles |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 12 | Host buffer byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at `host_addr` (combinational) |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data bus out |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_in | input | 8 | Data bus in |
| nf_rb | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Run in progress |
| done_irq | output | 1 | Completion pulse |
| timeout_flag | output | 1 | Last run ended on a ready-wait timeout |

## Verification
The assertions take for granted that the configuration inputs stay stable from an accepted start until the completion pulse. They also assume the host port does not write the buffer while a read step is storing device data. The bench changes the step list, addresses, geometry and buffer selection only while the block is idle. It fills or empties the buffer only before a run starts or after it ends. The device model changes `nf_dq_in` only after a read strobe rises, and it moves `nf_rb` only on falling clock edges.

// File: rtl/nfseq_pkg.sv
// Shared types for the NAND command sequencer.
// Assumes: step codes are 3 bits wide and their numbering is visible to software.
package nfseq_pkg;
    typedef enum logic [2:0] {
        OP_END   = 3'd0,
        OP_CMD0  = 3'd1,
        OP_CMD1  = 3'd2,
        OP_COL   = 3'd3,
        OP_ROW   = 3'd4,
        OP_WPAGE = 3'd5,
        OP_RPAGE = 3'd6,
        OP_WAIT  = 3'd7
    } nf_op_e;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_WAIT, SQ_FIN} sq_state_e;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;
endpackage

// File: rtl/nfseq_buf.sv
// Page buffer: one byte-wide array with two write sources and two read ports.
// The sequencer write has priority over the host write.
// Assumes: DEPTH is a power of two and both reads are combinational.
module nfseq_buf #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_waddr,
    input  logic [7:0]    seq_wdata,
    input  logic [AW-1:0] seq_raddr,
    output logic [7:0]    seq_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata
);
    logic [7:0] mem [DEPTH];

    // Store one byte per cycle; device read data wins over host data.
    always_ff @(posedge clk) begin
        if (seq_we)
            mem[seq_waddr] <= seq_wdata;
        else if (host_we)
            mem[host_addr] <= host_wdata;
    end

    assign seq_rdata  = mem[seq_raddr];
    assign host_rdata = mem[host_addr];
endmodule

// File: rtl/nfseq_io.sv
// Byte strobe engine: turns one byte request into a two-cycle strobe
// (one cycle low, one cycle high) on the write or read line.
// A new request is accepted during the high cycle, so bytes go back to back.
// Assumes: request fields stay valid in the cycle that accept is high.
module nfseq_io
    import nfseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_rd,
    input  logic       req_cle,
    input  logic       req_ale,
    input  logic [7:0] req_byte,
    output logic       accept,
    output logic       idle,
    output logic       rvalid,
    output logic [7:0] rdata,
    output logic       nf_cle,
    output logic       nf_ale,
    output logic       nf_we_n,
    output logic       nf_re_n,
    output logic [7:0] nf_dq_out,
    output logic       nf_dq_oe,
    input  logic [7:0] nf_dq_in
);
    ph_e        ph;
    logic       rd_q, cle_q, ale_q;
    logic [7:0] byte_q;

    assign accept = req && (ph != PH_LOW);
    assign idle   = (ph == PH_IDLE);
    assign rvalid = (ph == PH_HIGH) && rd_q;

    // Phase register: latch the request, then step through the low and high halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            rd_q   <= 1'b0;
            cle_q  <= 1'b0;
            ale_q  <= 1'b0;
            byte_q <= 8'h00;
            rdata  <= 8'h00;
        end else if (accept) begin
            ph     <= PH_LOW;
            rd_q   <= req_rd;
            cle_q  <= req_cle;
            ale_q  <= req_ale;
            byte_q <= req_byte;
        end else if (ph == PH_LOW) begin
            ph <= PH_HIGH;
            if (rd_q) rdata <= nf_dq_in;
        end else begin
            ph <= PH_IDLE;
        end
    end

    // Pin decode from the phase and the latched request.
    always_comb begin
        nf_we_n   = !((ph == PH_LOW) && !rd_q);
        nf_re_n   = !((ph == PH_LOW) && rd_q);
        nf_cle    = cle_q && (ph != PH_IDLE);
        nf_ale    = ale_q && (ph != PH_IDLE);
        nf_dq_oe  = (ph != PH_IDLE) && !rd_q;
        nf_dq_out = byte_q;
    end

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> (nf_dq_oe && $stable(nf_dq_out)));
    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);
endmodule

// File: rtl/nfseq_step.sv
// Step walker: fetches step codes in order, sizes each step in bytes,
// picks the byte source, tracks ready-wait timeout and signals completion.
// Assumes: configuration inputs are stable while busy; BUF_AW >= 3.
module nfseq_step
    import nfseq_pkg::*;
#(
    parameter int BUF_AW    = 12,
    parameter int ROW_BYTES = 3,
    parameter int SMALL_LEN = 528,
    parameter int LARGE_LEN = 2112,
    parameter int TMO_W     = 16,
    parameter int NSTEP     = 8,
    localparam int LEN_W    = $clog2(LARGE_LEN + 1),
    localparam int PTR_W    = $clog2(NSTEP) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3*NSTEP-1:0]     step_list,
    input  logic [7:0]             cmd0,
    input  logic [7:0]             cmd1,
    input  logic [15:0]            col_addr,
    input  logic [8*ROW_BYTES-1:0] row_addr,
    input  logic                   large_page,
    input  logic                   buf_mode,
    input  logic [2:0]             buf_sel,
    input  logic [TMO_W-1:0]       timeout_lim,
    input  logic                   nf_rb,
    input  logic                   io_accept,
    input  logic                   io_idle,
    input  logic                   io_rvalid,
    input  logic [7:0]             io_rdata,
    output logic                   io_req,
    output logic                   io_rd,
    output logic                   io_cle,
    output logic                   io_ale,
    output logic [7:0]             io_byte,
    output logic [BUF_AW-1:0]      buf_raddr,
    input  logic [7:0]             buf_rdata,
    output logic                   buf_we,
    output logic [BUF_AW-1:0]      buf_waddr,
    output logic [7:0]             buf_wdata,
    output logic                   busy,
    output logic                   done_irq,
    output logic                   timeout_flag
);
    sq_state_e         state;
    logic [PTR_W-1:0]  ptr;
    logic [LEN_W-1:0]  idx, nbytes, page_len;
    logic [BUF_AW-1:0] widx, base;
    logic [TMO_W-1:0]  tcnt;
    nf_op_e            op;
    logic [7:0]        row_byte;

    // Current step code; a pointer past the list reads as end.
    always_comb begin
        if (ptr >= PTR_W'(NSTEP)) op = OP_END;
        else op = nf_op_e'(step_list[3*ptr[PTR_W-2:0] +: 3]);
    end

    // Page length and buffer base from geometry and buffer selection.
    always_comb begin
        page_len = large_page ? LEN_W'(LARGE_LEN) : LEN_W'(SMALL_LEN);
        if (buf_mode) base = BUF_AW'(buf_sel) << (BUF_AW - 3);
        else          base = BUF_AW'(buf_sel[0]) << (BUF_AW - 1);
    end

    // Byte count of the current step.
    always_comb begin
        case (op)
            OP_COL:            nbytes = large_page ? LEN_W'(2) : LEN_W'(1);
            OP_ROW:            nbytes = LEN_W'(ROW_BYTES);
            OP_WPAGE, OP_RPAGE: nbytes = page_len;
            default:           nbytes = LEN_W'(1);
        endcase
    end

    // Row byte chosen by the byte index, least significant first.
    always_comb begin
        row_byte = row_addr[7:0];
        for (int i = 0; i < ROW_BYTES; i++)
            if (idx == LEN_W'(i)) row_byte = row_addr[8*i +: 8];
    end

    // Byte request toward the strobe engine.
    always_comb begin
        io_req = (state == SQ_RUN) && (op != OP_END) && (op != OP_WAIT);
        io_rd  = (op == OP_RPAGE);
        io_cle = (op == OP_CMD0) || (op == OP_CMD1);
        io_ale = (op == OP_COL) || (op == OP_ROW);
        case (op)
            OP_CMD0: io_byte = cmd0;
            OP_CMD1: io_byte = cmd1;
            OP_COL:  io_byte = (idx == LEN_W'(0)) ? col_addr[7:0] : col_addr[15:8];
            OP_ROW:  io_byte = row_byte;
            default: io_byte = buf_rdata;
        endcase
    end

    assign buf_raddr = base + BUF_AW'(idx);
    assign buf_waddr = base + widx;
    assign buf_we    = io_rvalid;
    assign buf_wdata = io_rdata;
    assign busy      = (state != SQ_IDLE);

    // Sequence control: step pointer, byte index, ready wait and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            ptr          <= '0;
            idx          <= '0;
            widx         <= '0;
            tcnt         <= '0;
            done_irq     <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            if (buf_we) widx <= widx + 1'b1;
            case (state)
                SQ_IDLE: if (start) begin
                    state        <= SQ_RUN;
                    ptr          <= '0;
                    idx          <= '0;
                    widx         <= '0;
                    timeout_flag <= 1'b0;
                end
                SQ_RUN: begin
                    if (op == OP_END) begin
                        state <= SQ_FIN;
                    end else if (op == OP_WAIT) begin
                        state <= SQ_WAIT;
                        tcnt  <= '0;
                    end else if (io_accept) begin
                        if (idx == nbytes - 1'b1) begin
                            idx <= '0;
                            ptr <= ptr + 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                SQ_WAIT: if (io_idle) begin
                    if (nf_rb) begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_RUN;
                    end else if (tcnt == timeout_lim) begin
                        timeout_flag <= 1'b1;
                        state        <= SQ_FIN;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: if (io_idle) begin
                    done_irq <= 1'b1;
                    state    <= SQ_IDLE;
                end
            endcase
        end
    end

    assert_irq_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq);
    assert_tmo_from_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(state == SQ_WAIT));
    assert_ptr_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(NSTEP));
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
endmodule

// File: rtl/nand_cmd_seq.sv
// Top level of the NAND command sequencer. It ties the step walker,
// the byte strobe engine and the page buffer together.
// Assumes: BUF_BYTES is a power of two and holds at least one large page.
module nand_cmd_seq #(
    parameter int BUF_BYTES   = 4096,
    parameter int ROW_BYTES   = 3,
    parameter int SMALL_DATA  = 512,
    parameter int SMALL_SPARE = 16,
    parameter int LARGE_DATA  = 2048,
    parameter int LARGE_SPARE = 64,
    parameter int TMO_W       = 16,
    localparam int BUF_AW     = $clog2(BUF_BYTES),
    localparam int NSTEP      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3*NSTEP-1:0]     step_list,
    input  logic [7:0]             cmd0,
    input  logic [7:0]             cmd1,
    input  logic [15:0]            col_addr,
    input  logic [8*ROW_BYTES-1:0] row_addr,
    input  logic                   large_page,
    input  logic                   buf_mode,
    input  logic [2:0]             buf_sel,
    input  logic [TMO_W-1:0]       timeout_lim,
    input  logic                   host_we,
    input  logic [BUF_AW-1:0]      host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic                   nf_cle,
    output logic                   nf_ale,
    output logic                   nf_we_n,
    output logic                   nf_re_n,
    output logic [7:0]             nf_dq_out,
    output logic                   nf_dq_oe,
    input  logic [7:0]             nf_dq_in,
    input  logic                   nf_rb,
    output logic                   busy,
    output logic                   done_irq,
    output logic                   timeout_flag
);
    logic              io_req, io_rd, io_cle, io_ale, io_accept, io_idle, io_rvalid;
    logic [7:0]        io_byte, io_rdata, buf_rdata, buf_wdata;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_raddr, buf_waddr;

    nfseq_step #(
        .BUF_AW(BUF_AW), .ROW_BYTES(ROW_BYTES),
        .SMALL_LEN(SMALL_DATA + SMALL_SPARE), .LARGE_LEN(LARGE_DATA + LARGE_SPARE),
        .TMO_W(TMO_W), .NSTEP(NSTEP)
    ) step_i (
        .clk(clk), .rst_n(rst_n), .start(start), .step_list(step_list),
        .cmd0(cmd0), .cmd1(cmd1), .col_addr(col_addr), .row_addr(row_addr),
        .large_page(large_page), .buf_mode(buf_mode), .buf_sel(buf_sel),
        .timeout_lim(timeout_lim), .nf_rb(nf_rb),
        .io_accept(io_accept), .io_idle(io_idle), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .io_req(io_req), .io_rd(io_rd), .io_cle(io_cle), .io_ale(io_ale), .io_byte(io_byte),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .busy(busy), .done_irq(done_irq), .timeout_flag(timeout_flag)
    );

    nfseq_io io_i (
        .clk(clk), .rst_n(rst_n), .req(io_req), .req_rd(io_rd), .req_cle(io_cle),
        .req_ale(io_ale), .req_byte(io_byte), .accept(io_accept), .idle(io_idle),
        .rvalid(io_rvalid), .rdata(io_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in)
    );

    nfseq_buf #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) buf_i (
        .clk(clk), .seq_we(buf_we), .seq_waddr(buf_waddr), .seq_wdata(buf_wdata),
        .seq_raddr(buf_raddr), .seq_rdata(buf_rdata),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );
endmodule

// File: tb/nand_cmd_seq_tb_top.sv
// Scoreboard bench: driver tasks queue the expected latched bytes; a monitor
// on the write strobe pops and compares them; a read model feeds data.
module nand_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] O_END = 3'd0, O_C0 = 3'd1, O_C1 = 3'd2, O_COL = 3'd3,
                           O_ROW = 3'd4, O_WP = 3'd5, O_RP = 3'd6, O_WT = 3'd7;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n = 1'b0, start = 1'b0, large_page = 1'b0, buf_mode = 1'b0;
    logic [23:0] step_list = '0, row_addr = 24'h123456;
    logic [7:0]  cmd0 = 8'h85, cmd1 = 8'h21, host_wdata = '0, host_rdata, nf_dq_out, nf_dq_in;
    logic [15:0] col_addr = 16'hA3C7, timeout_lim = 16'd100;
    logic [2:0]  buf_sel = '0;
    logic        host_we = 1'b0, nf_rb = 1'b1;
    logic [11:0] host_addr = '0;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, busy, done_irq, timeout_flag;

    nand_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .step_list(step_list), .cmd0(cmd0),
        .cmd1(cmd1), .col_addr(col_addr), .row_addr(row_addr), .large_page(large_page),
        .buf_mode(buf_mode), .buf_sel(buf_sel), .timeout_lim(timeout_lim),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
        .nf_rb(nf_rb), .busy(busy), .done_irq(done_irq), .timeout_flag(timeout_flag)
    );

    int total = 0, bad = 0, cyc = 0, rd_count = 0;
    logic armed = 1'b0;
    logic [9:0] exp_q[$];
    string tag_q[$];
    logic [9:0] mon_got, mon_exp;
    string mon_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] rpat(input int k);
        return 8'(k * 13 + 5);
    endfunction

    function automatic logic [7:0] wpat(input int k);
        return 8'(k * 3 + 1);
    endfunction

    function automatic logic [23:0] pk(input logic [2:0] s0, s1, s2, s3, s4, s5, s6, s7);
        return {s7, s6, s5, s4, s3, s2, s1, s0};
    endfunction

    task automatic push(input logic c, input logic a, input logic [7:0] b, input string tag);
        exp_q.push_back({c, a, b});
        tag_q.push_back(tag);
    endtask

    // Device read model: next byte appears after each read strobe rises.
    assign nf_dq_in = rpat(rd_count);
    always @(posedge nf_re_n) if (armed) rd_count++;

    // Monitor: compare each byte latched on the write strobe with the queue head.
    always begin
        @(posedge nf_we_n);
        #1;
        if (armed) begin
            mon_got = {nf_cle, nf_ale, nf_dq_out};
            chk(nf_dq_oe === 1'b1, "R4", "bus driven at strobe rise", nf_dq_oe, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected byte", mon_got, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                chk(mon_got === mon_exp, mon_tag, "latched {cle,ale,byte}", mon_got, mon_exp);
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 0);
            finish_up();
        end
    end

    task automatic run_seq(input string tag, output int n);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (done_irq !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done_irq === 1'b1, tag, "completion pulse", done_irq, 1);
        chk(busy === 1'b0, "R10", "busy low with pulse", busy, 0);
        @(negedge clk);
        chk(done_irq === 1'b0, "R10", "pulse lasts one cycle", done_irq, 0);
        chk(exp_q.size() == 0, tag, "bytes still expected", exp_q.size(), 0);
    endtask

    initial begin
        int n;
        logic [7:0] v;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy === 0 && done_irq === 0 && timeout_flag === 0, "R11", "status after reset",
            {busy, done_irq, timeout_flag}, 0);
        chk(nf_we_n === 1 && nf_re_n === 1, "R11", "strobes high after reset", {nf_we_n, nf_re_n}, 3);
        chk(nf_cle === 0 && nf_ale === 0 && nf_dq_oe === 0, "R11", "latches idle after reset",
            {nf_cle, nf_ale, nf_dq_oe}, 0);
        armed = 1'b1;

        // R2 R3 small page: one column byte, three row bytes low first
        step_list = pk(O_C0, O_COL, O_ROW, O_C1, O_WT, O_END, O_C0, O_C0);
        push(1, 0, 8'h85, "R2"); push(0, 1, 8'hC7, "R3");
        push(0, 1, 8'h56, "R3"); push(0, 1, 8'h34, "R3"); push(0, 1, 8'h12, "R3");
        push(1, 0, 8'h21, "R2");
        run_seq("R1", n);
        chk(rd_count == 0, "R4", "no read strobes in command run", rd_count, 0);

        // R1 order taken from the list; R3 large page column gives two bytes
        large_page = 1'b1;
        step_list = pk(O_ROW, O_C1, O_COL, O_C0, O_END, O_C1, O_C1, O_C1);
        push(0, 1, 8'h56, "R1"); push(0, 1, 8'h34, "R1"); push(0, 1, 8'h12, "R1");
        push(1, 0, 8'h21, "R1"); push(0, 1, 8'hC7, "R3"); push(0, 1, 8'hA3, "R3");
        push(1, 0, 8'h85, "R1");
        run_seq("R1", n);

        // R1 eight steps without an end code stop after step 7
        step_list = pk(O_C0, O_C0, O_C0, O_C0, O_C0, O_C0, O_C0, O_C0);
        for (int i = 0; i < 8; i++) push(1, 0, 8'h85, "R1");
        run_seq("R1", n);

        // R5 R7 small page write from slot 3 of eight (base 1536); R10 start while busy
        large_page = 1'b0; buf_mode = 1'b1; buf_sel = 3'd3;
        for (int k = 0; k < 528; k++) begin
            @(negedge clk);
            host_we = 1'b1; host_addr = 12'(1536 + k); host_wdata = wpat(k);
        end
        @(negedge clk); host_we = 1'b0;
        step_list = pk(O_C0, O_WP, O_C1, O_END, O_END, O_END, O_END, O_END);
        push(1, 0, 8'h85, "R2");
        for (int k = 0; k < 528; k++) push(0, 0, wpat(k), "R5");
        push(1, 0, 8'h21, "R2");
        fork
            run_seq("R5", n);
            begin
                repeat (200) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (50) @(negedge clk);
        chk(busy === 1'b0, "R10", "start during run ignored", busy, 0);

        // R6 R7 large page read into half 1 (base 2048), wraps past the top
        large_page = 1'b1; buf_mode = 1'b0; buf_sel = 3'd1; rd_count = 0;
        step_list = pk(O_C0, O_COL, O_ROW, O_C1, O_WT, O_RP, O_END, O_END);
        push(1, 0, 8'h85, "R2"); push(0, 1, 8'hC7, "R3"); push(0, 1, 8'hA3, "R3");
        push(0, 1, 8'h56, "R3"); push(0, 1, 8'h34, "R3"); push(0, 1, 8'h12, "R3");
        push(1, 0, 8'h21, "R2");
        run_seq("R6", n);
        chk(rd_count == 2112, "R6", "read strobe count", rd_count, 2112);
        errs = 0;
        for (int k = 0; k < 2112; k++) begin
            @(negedge clk);
            host_addr = 12'(2048 + k);
            #1;
            v = host_rdata;
            if (v !== rpat(k)) errs++;
        end
        chk(errs == 0, "R6", "stored page mismatches (base 2048, R7)", errs, 0);

        // R8 short busy period: second command waits for ready
        large_page = 1'b0; timeout_lim = 16'd100; nf_rb = 1'b0;
        step_list = pk(O_C0, O_WT, O_C1, O_END, O_END, O_END, O_END, O_END);
        push(1, 0, 8'h85, "R8"); push(1, 0, 8'h21, "R8");
        fork
            run_seq("R8", n);
            begin
                repeat (30) @(negedge clk);
                chk(exp_q.size() == 1, "R8", "held while busy", exp_q.size(), 1);
                nf_rb = 1'b1;
            end
        join
        chk(timeout_flag === 1'b0, "R8", "no timeout", timeout_flag, 0);

        // R9 ready never returns: abort, later steps skipped
        timeout_lim = 16'd20; nf_rb = 1'b0;
        push(1, 0, 8'h85, "R9");
        run_seq("R9", n);
        chk(timeout_flag === 1'b1, "R9", "timeout flag set", timeout_flag, 1);
        chk(n >= 20, "R9", "wait lasted the limit", n, 20);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "skipped steps stay silent", exp_q.size(), 0);

        // R9 next start clears the flag
        nf_rb = 1'b1;
        step_list = pk(O_C1, O_END, O_END, O_END, O_END, O_END, O_END, O_END);
        push(1, 0, 8'h21, "R2");
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(timeout_flag === 1'b0, "R9", "flag cleared on start", timeout_flag, 0);
        n = 0;
        while (busy === 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "second command issued", exp_q.size(), 0);

        finish_up();
    end
endmodule